// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Product/Quotient Register Pair

This block is a sequential arithmetic unit that a processor pipeline drives for 32-bit multiplies and divides. A start pulse supplies an operation code and two operands. The unit then spends a fixed number of cycles on them: shift-and-add for a multiply, and restoring division for a divide. It writes the result into a dedicated pair of result registers, the upper word (HI) and the lower word (LO).

A multiply leaves the 64-bit product split across the pair. A divide leaves the quotient in LO and the remainder in HI. The core reads either register back through a read port. While an operation is in flight, a read request raises a stall output, so the core can hold its move-from-register instruction until the registers carry the new result.

Top module: `mdu_top`

## Requirements
- R1: After reset, HI and LO both read as zero, and `busy_o` and `stall_o` are low.
- R2: Operation code 2'b00 is a signed multiply: the 64-bit two's-complement product of `opa_i` and `opb_i` has its upper word in HI and its lower word in LO.
- R3: Operation code 2'b01 is an unsigned multiply: the 64-bit unsigned product is split the same way, upper word in HI and lower word in LO.
- R4: Operation code 2'b11 is an unsigned divide of `opa_i` by `opb_i`: the quotient goes to LO and the remainder to HI.
- R5: Operation code 2'b10 is a signed divide whose quotient, in LO, is truncated toward zero. The case -2^31 / -1 yields 0x80000000.
- R6: In a signed divide the remainder in HI carries the sign of the dividend, or is zero.
- R7: A start accepted while the unit is idle raises `busy_o` from the next cycle for exactly W+1 cycles (33 by default). HI and LO hold the new result in the first cycle with `busy_o` low.
- R8: A start while `busy_o` is high is ignored: the running operation finishes with its original operands and operation code.
- R9: `stall_o` is high exactly when `rd_req_i` is high while `busy_o` is high.
- R10: HI and LO change only when an operation completes. While `busy_o` is high, reads return the previous result.
- R11: `rd_data_o` returns LO when `rd_sel_i` is 0 and HI when `rd_sel_i` is 1.
- R12: A divide by zero completes with the same latency as any other operation. Its HI and LO contents are not specified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| rd_req_i | input | 1 | Move-from-register request |
| rd_sel_i | input | 1 | 0 selects LO, 1 selects HI |
| busy_o | output | 1 | Operation in progress |
| stall_o | output | 1 | Read must wait; result not yet written |
| rd_data_o | output | 32 | Selected result register |

## Verification
A corrupted partial product or partial remainder does not show at the ports while the unit runs, because HI and LO hold the old result. It shows in the first idle cycle after completion, W+1 cycles after the start, as a wrong word on the read port. A miscounted iteration counter shows as a `busy_o` pulse of the wrong length, and the result is usually wrong as well. A wrong sign flag for a signed operation shows as a negated word in HI, in LO, or in both. Random operands, mixed with the extreme values of each operand width, make these faults show up within a few operations.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    MD_MULS = 2'b00,
    MD_MULU = 2'b01,
    MD_DIVS = 2'b10,
    MD_DIVU = 2'b11
  } md_op_e;

  // what the result fix-up stage must do once the iterations are over
  typedef struct packed {
    logic is_div;
    logic neg_lo;
    logic neg_hi;
  } md_job_t;
endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output md_job_t      job_o
);
  // magnitude of a value, treating it as signed when sgn is set
  function automatic logic [W-1:0] mag_of(input logic [W-1:0] v, input logic sgn);
    if (sgn && v[W-1]) return (~v) + 1'b1;
    return v;
  endfunction

  logic is_signed;
  logic a_neg;
  logic b_neg;

  always_comb begin
    is_signed = (op_i == MD_MULS) || (op_i == MD_DIVS);
    a_neg     = is_signed && opa_i[W-1];
    b_neg     = is_signed && opb_i[W-1];
    mag_a_o   = mag_of(opa_i, is_signed);
    mag_b_o   = mag_of(opb_i, is_signed);
    job_o.is_div = op_i[1];
    if (op_i[1]) begin
      job_o.neg_lo = a_neg ^ b_neg;   // quotient sign
      job_o.neg_hi = a_neg;           // remainder follows the dividend
    end else begin
      job_o.neg_lo = a_neg ^ b_neg;   // whole product negated
      job_o.neg_hi = a_neg ^ b_neg;
    end
  end
endmodule

// File: rtl/mdu_iter_core.sv
module mdu_iter_core
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  md_job_t      job_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic         busy_o,
  output logic         done_o,
  output md_job_t      job_o,
  output logic [W-1:0] acc_hi_o,
  output logic [W-1:0] acc_lo_o
);
  localparam int CW = $clog2(W + 1);

  logic          run_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;
  md_job_t       job_q;
  logic [W-1:0]  hi_q;
  logic [W-1:0]  lo_q;
  logic [W-1:0]  opnd_q;
  logic [W-1:0]  hi_n;
  logic [W-1:0]  lo_n;
  logic          last_step;

  // one shift-add step: conditional add of the multiplicand, then shift right
  function automatic logic [2*W-1:0] mul_step(input logic [W-1:0] h,
                                              input logic [W-1:0] l,
                                              input logic [W-1:0] m);
    logic [W:0] s;
    s = {1'b0, h} + (l[0] ? {1'b0, m} : {(W+1){1'b0}});
    return {s[W:1], s[0], l[W-1:1]};
  endfunction

  // one restoring-division step: shift in a dividend bit, trial subtract
  function automatic logic [2*W-1:0] div_step(input logic [W-1:0] r,
                                              input logic [W-1:0] q,
                                              input logic [W-1:0] d);
    logic [W:0] sh;
    logic [W:0] df;
    logic       ge;
    sh = {r, q[W-1]};
    df = sh - {1'b0, d};
    ge = (sh >= {1'b0, d});
    return {(ge ? df[W-1:0] : sh[W-1:0]), q[W-2:0], ge};
  endfunction

  always_comb begin
    if (job_q.is_div) {hi_n, lo_n} = div_step(hi_q, lo_q, opnd_q);
    else              {hi_n, lo_n} = mul_step(hi_q, lo_q, opnd_q);
    last_step = run_q && (cnt_q == CW'(W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      job_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      opnd_q <= '0;
    end else if (go_i) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
      job_q  <= job_i;
      hi_q   <= '0;
      lo_q   <= mag_a_i;
      opnd_q <= mag_b_i;
    end else if (run_q) begin
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      cnt_q  <= cnt_q + 1'b1;
      run_q  <= !last_step;
      done_q <= last_step;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o   = run_q | done_q;
  assign done_o   = done_q;
  assign job_o    = job_q;
  assign acc_hi_o = hi_q;
  assign acc_lo_o = lo_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < CW'(W))) else $error("counter overran");            // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done held");                          // R7
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && job_q.is_div && opnd_q != '0) |-> (hi_q < opnd_q))
    else $error("partial remainder too large");                            // R4
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !last_step) |=> run_q) else $error("run aborted");           // R8
endmodule

// File: rtl/mdu_hilo_regs.sv
module mdu_hilo_regs
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done_i,
  input  md_job_t      job_i,
  input  logic [W-1:0] acc_hi_i,
  input  logic [W-1:0] acc_lo_i,
  input  logic         rd_sel_i,
  output logic [W-1:0] rd_data_o
);
  logic [W-1:0]   hi_q;
  logic [W-1:0]   lo_q;
  logic [2*W-1:0] fixed;

  // apply the signs recorded at start to the unsigned iteration result
  function automatic logic [2*W-1:0] sign_fix(input md_job_t j,
                                              input logic [W-1:0] h,
                                              input logic [W-1:0] l);
    logic [2*W-1:0] full;
    logic [W-1:0]   rh;
    logic [W-1:0]   rl;
    if (!j.is_div) begin
      full = {h, l};
      return j.neg_lo ? (~full) + 1'b1 : full;
    end
    rh = j.neg_hi ? (~h) + 1'b1 : h;
    rl = j.neg_lo ? (~l) + 1'b1 : l;
    return {rh, rl};
  endfunction

  assign fixed = sign_fix(job_i, acc_hi_i, acc_lo_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (done_i) begin
      hi_q <= fixed[2*W-1:W];
      lo_q <= fixed[W-1:0];
    end
  end

  assign rd_data_o = rd_sel_i ? hi_q : lo_q;

  AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> ($stable(hi_q) && $stable(lo_q))) else $error("HI/LO moved"); // R10
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         rd_req_i,
  input  logic         rd_sel_i,
  output logic         busy_o,
  output logic         stall_o,
  output logic [W-1:0] rd_data_o
);
  logic [W-1:0] mag_a;
  logic [W-1:0] mag_b;
  md_job_t      job_new;
  md_job_t      job_run;
  logic [W-1:0] acc_hi;
  logic [W-1:0] acc_lo;
  logic         core_busy;
  logic         core_done;
  logic         accept;

  assign accept  = start_i && !core_busy;
  assign busy_o  = core_busy;
  assign stall_o = rd_req_i && core_busy;

  mdu_operand_prep #(.W(W)) u_prep (
    .op_i    (op_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .mag_a_o (mag_a),
    .mag_b_o (mag_b),
    .job_o   (job_new)
  );

  mdu_iter_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (accept),
    .job_i    (job_new),
    .mag_a_i  (mag_a),
    .mag_b_i  (mag_b),
    .busy_o   (core_busy),
    .done_o   (core_done),
    .job_o    (job_run),
    .acc_hi_o (acc_hi),
    .acc_lo_o (acc_lo)
  );

  mdu_hilo_regs #(.W(W)) u_hilo (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (core_done),
    .job_i     (job_run),
    .acc_hi_i  (acc_hi),
    .acc_lo_i  (acc_lo),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o)
  );

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o) else $error("start not taken");        // R7
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !busy_o) else $error("busy after completion");            // R7
  AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !stall_o) else $error("stall while idle");                  // R9
endmodule

// File: tb/test_mdu_top.sv
module test_mdu_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic         rd_req_i = 1'b0;
  logic         rd_sel_i = 1'b0;
  logic         busy_o;
  logic         stall_o;
  logic [W-1:0] rd_data_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [W-1:0] prev_hi = '0;
  logic [W-1:0] prev_lo = '0;

  always #2.5 clk = ~clk;   // 200 MHz

  mdu_top #(.W(W)) i_mdu_top (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    total = total + 1;
    if (act !== exp_v) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // reference: {HI, LO} for a given operation
  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'h0, a};
    ub = {32'h0, b};
    case (op)
      2'b00: return 64'(sa * sb);
      2'b01: return ua * ub;
      2'b10: begin
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: return {32'((ua % ub)), 32'((ua / ub))};
    endcase
  endfunction

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel_i = sel;
    #0.5;
    v = rd_data_o;
  endtask

  // launch, watch busy, then read both registers
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input bit try_restart, input bit check_val);
    int n;
    logic [63:0] exp_v;
    logic [31:0] h, l;
    string tag;
    exp_v = model(op, a, b);
    tag = op[1] ? (op[0] ? "R4 udiv" : "R5/R6 sdiv") : (op[0] ? "R3 umul" : "R2 smul");
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n < 100) begin
      n++;
      if (n == 4 && try_restart) begin
        start_i = 1'b1; op_i = ~op; opa_i = ~a; opb_i = b ^ 32'h5a5a_0f0f;
      end
      if (n == 5) begin
        start_i = 1'b0;
        rd_req_i = 1'b1;
        rd(1'b1, h);
        chk("R9 stall while busy", {63'h0, stall_o}, 64'h1);
        chk("R10 HI held while busy", {32'h0, h}, {32'h0, prev_hi});
        rd(1'b0, l);
        chk("R10 LO held while busy", {32'h0, l}, {32'h0, prev_lo});
        rd_req_i = 1'b0;
      end
      @(negedge clk);
    end
    chk(b == 0 && op[1] ? "R12 div-by-zero latency" : "R7 busy length", 64'(n), 64'(W + 1));
    rd_req_i = 1'b1;
    #0.5;
    chk("R9 no stall when idle", {63'h0, stall_o}, 64'h0);
    rd(1'b1, h);
    rd(1'b0, l);
    rd_req_i = 1'b0;
    if (check_val && !(op[1] && b == 0)) begin
      chk(try_restart ? "R8 restart ignored" : tag, {h, l}, exp_v);
      if (op == 2'b10 && h != 0)
        chk("R6 remainder sign", {63'h0, h[31]}, {63'h0, a[31]});
    end
    prev_hi = h;
    prev_lo = l;
  endtask

  initial begin
    logic [31:0] v;
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy reset", {63'h0, busy_o}, 64'h0);
    chk("R1 stall reset", {63'h0, stall_o}, 64'h0);
    rd(1'b0, v); chk("R1 LO reset", {32'h0, v}, 64'h0);
    rd(1'b1, v); chk("R1 HI reset", {32'h0, v}, 64'h0);

    // directed corners
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0, 1);
    run_op(2'b00, 32'hffff_ffff, 32'h0000_0007, 0, 1);
    run_op(2'b01, 32'hffff_ffff, 32'hffff_ffff, 0, 1);
    run_op(2'b11, 32'hffff_ffff, 32'h0000_0001, 0, 1);
    run_op(2'b11, 32'h0000_0005, 32'h0000_0009, 0, 1);
    run_op(2'b10, 32'h8000_0000, 32'hffff_ffff, 0, 1);
    run_op(2'b10, -32'sd7, 32'd2, 0, 1);
    run_op(2'b10, 32'd7, -32'sd2, 0, 1);
    run_op(2'b10, -32'sd9, -32'sd4, 0, 1);
    run_op(2'b01, 32'h1234_5678, 32'h9abc_def0, 1, 1);
    run_op(2'b11, 32'h0000_1234, 32'h0, 0, 0);
    // R11: select picks the right register after a known product
    run_op(2'b01, 32'h0001_0000, 32'h0003_0000, 0, 1);
    rd(1'b0, v); chk("R11 sel=0 gives LO", {32'h0, v}, 64'h0);
    rd(1'b1, v); chk("R11 sel=1 gives HI", {32'h0, v}, 64'h3);

    // constrained random
    void'($urandom(32'd4242));
    for (int i = 0; i < 300; i++) begin
      logic [1:0] op;
      logic [31:0] a, b;
      op = 2'($urandom);
      a = $urandom;
      b = $urandom;
      case ($urandom % 4)
        0: b = b & 32'h0000_00ff;
        1: a = a | 32'h8000_0000;
        default: ;
      endcase
      if (op[1] && b == 0) b = 32'h1;
      run_op(op, a, b, ($urandom % 8) == 0, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule